// File: doc/BRIEF.md
# Far-Address Program Counter Unit

This block holds the 24-bit program counter of a CPU whose address space grows from 16 to 24 bits, and it sequences every control-flow transfer that moves that counter. A decoder hands it one command at a time: a near or far jump, a near or far call, a far return, interrupt entry, return from interrupt, or a relative branch. Near transfers replace only the low 16 bits and leave the top 8 bits where they were. Far transfers, interrupt entry and interrupt return move all 24 bits.

Calls and interrupt entry serialise the current counter onto a byte-wide push port. Returns reassemble it from a byte-wide pop port. The stack pointer is kept inside the block. Interrupt entry then reads a 3-byte vector from a table at the top of the address space and jumps to it.

The sequencer has five states. `ST_IDLE` accepts commands. `ST_PUSH` emits one byte per cycle. `ST_POP` takes in one byte per cycle. `ST_VEC` reads one vector byte per cycle. `ST_BRANCH` is the second cycle of a branch. The transitions are:
- IDLE→IDLE: a near or far jump.
- IDLE→PUSH: a call or interrupt entry.
- IDLE→POP: a far return or return from interrupt.
- IDLE→BRANCH: a branch.
- PUSH→IDLE: the last push of a call.
- PUSH→VEC: the last push of an interrupt entry.
- POP→IDLE: the last pop.
- VEC→IDLE: the last vector byte.
- BRANCH→IDLE: always.

Top module: `far_pc_unit`

## Requirements
- R1: After reset `pc` is 0x000000, `sp` is 0x0100, `busy` is low, and no strobe is asserted.
- R2: Command 0 (near jump) accepted in idle replaces `pc[15:0]` with `target[15:0]` at the accepting edge and keeps `pc[23:16]`.
- R3: Command 1 (far jump) loads all 24 bits of `target` into `pc` at the accepting edge.
- R4: Command 2 (near call) pushes 2 bytes, `pc[7:0]` first and then `pc[15:8]`. After that it loads `target[15:0]` into the low 16 bits and keeps the upper 8 bits.
- R5: Command 3 (far call) pushes 3 bytes in the order low, middle, high. After that it loads all 24 bits of `target`.
- R6: Each push writes at `sp-1` and decrements `sp` by one. Each pop reads the byte at `sp` and increments `sp` by one.
- R7: Command 4 (far return) pops 3 bytes. The first byte popped becomes `pc[23:16]`, the second `pc[15:8]` and the third `pc[7:0]`.
- R8: Command 5 (interrupt entry) pushes the full PC as in R5. It then reads the bytes at 0xFFFFF0 + 3*`exc_num` + 0, 1 and 2, in that order, with the lowest address holding `pc[7:0]`, and loads all 24 bits.
- R9: Command 6 (return from interrupt) restores all 24 bits of `pc` from 3 pops, in the same order as R7.
- R10: Command 7 (branch) takes two cycles. At the second edge `pc` becomes `pc` + sign-extended `target[15:0]` modulo 2^24 if `taken` is set, and is left unchanged otherwise.
- R11: `cmd_valid` is ignored while `busy` is high.
- R12: At most one of `push_en`, `pop_en` and `vec_rd` is high in any cycle, and all three are low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 3 | Command code (0 to 7, see R2 to R10) |
| target | input | 24 | Jump or call target; low 16 bits are the branch offset |
| taken | input | 1 | Branch condition for command 7 |
| exc_num | input | 2 | Exception number for command 5 |
| busy | output | 1 | Sequence in progress |
| pc | output | 24 | Program counter |
| sp | output | 16 | Stack pointer |
| push_en | output | 1 | Push strobe |
| push_data | output | 8 | Byte to push |
| pop_en | output | 1 | Pop strobe |
| pop_data | input | 8 | Byte at `sp`, valid in the same cycle |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 24 | Vector byte address |
| vec_data | input | 8 | Vector byte, valid in the same cycle |

## Verification
The checker watches every cycle for the following:
- the one-edge effect of near and far jumps on the counter;
- the step of the stack pointer after each push or pop;
- exclusive, idle-quiet strobes;
- vector addresses that stay inside the table.

Byte order on the stack, reassembly of popped and vector bytes, branch arithmetic with wrap-around, and the rejection of commands while busy are shown only by the directed scenarios. Those scenarios compare the stack image and the final counter against hand-computed values.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
    typedef enum logic [2:0] {
        OP_JMP   = 3'd0,
        OP_JMPF  = 3'd1,
        OP_CALL  = 3'd2,
        OP_CALLF = 3'd3,
        OP_RETF  = 3'd4,
        OP_IRQ   = 3'd5,
        OP_RTI   = 3'd6,
        OP_BRA   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_VEC,
        ST_BRANCH
    } state_e;
endpackage

// File: rtl/fpu_sp_ctr.sv
module fpu_sp_ctr #(
    parameter int SP_W = 16,
    parameter logic [SP_W-1:0] SP_RESET = 16'h0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp
);
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_RESET;
        else if (dec) sp <= sp - 1'b1;
        else if (inc) sp <= sp + 1'b1;
    end
endmodule

// File: rtl/fpu_vec_gen.sv
module fpu_vec_gen #(
    parameter int PC_W  = 24,
    parameter int EXC_W = 2,
    parameter int NB    = 3,
    parameter int CNT_W = 2,
    parameter logic [PC_W-1:0] VEC_BASE = 24'hFFFFF0
) (
    input  logic [EXC_W-1:0] exc,
    input  logic [CNT_W-1:0] idx,
    output logic [PC_W-1:0]  addr
);
    always_comb begin
        addr = VEC_BASE + PC_W'(exc) * PC_W'(NB) + PC_W'(idx);
    end
endmodule

// File: rtl/far_pc_unit.sv
module far_pc_unit
    import fpu_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int NEAR_W = 16,
    parameter int BYTE_W = 8,
    parameter int SP_W   = 16,
    parameter int EXC_W  = 2,
    parameter logic [PC_W-1:0] PC_RESET = 24'h000000,
    parameter logic [SP_W-1:0] SP_RESET = 16'h0100,
    parameter logic [PC_W-1:0] VEC_BASE = 24'hFFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic [PC_W-1:0]   target,
    input  logic              taken,
    input  logic [EXC_W-1:0]  exc_num,
    output logic              busy,
    output logic [PC_W-1:0]   pc,
    output logic [SP_W-1:0]   sp,
    output logic              push_en,
    output logic [BYTE_W-1:0] push_data,
    output logic              pop_en,
    input  logic [BYTE_W-1:0] pop_data,
    output logic              vec_rd,
    output logic [PC_W-1:0]   vec_addr,
    input  logic [BYTE_W-1:0] vec_data
);
    localparam int NB      = PC_W / BYTE_W;
    localparam int NEAR_NB = NEAR_W / BYTE_W;
    localparam int CNT_W   = $clog2(NB + 1);
    localparam int HI_W    = PC_W - NEAR_W;

    state_e              state, state_nx;
    op_e                 op;
    logic [CNT_W-1:0]    cnt, nbytes;
    logic                far_q, irq_q, taken_q, accept, last;
    logic [PC_W-1:0]     tgt_q, acc;
    logic [EXC_W-1:0]    exc_q;
    logic [PC_W-1:0]     pc_q;

    assign op     = op_e'(cmd);
    assign accept = cmd_valid && (state == ST_IDLE);
    assign last   = (cnt == nbytes - 1'b1);

    fpu_sp_ctr #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n), .dec(push_en), .inc(pop_en), .sp(sp)
    );

    fpu_vec_gen #(.PC_W(PC_W), .EXC_W(EXC_W), .NB(NB), .CNT_W(CNT_W),
                  .VEC_BASE(VEC_BASE)) u_vec (
        .exc(exc_q), .idx(cnt), .addr(vec_addr)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                unique case (op)
                    OP_CALL, OP_CALLF, OP_IRQ: state_nx = ST_PUSH;
                    OP_RETF, OP_RTI:           state_nx = ST_POP;
                    OP_BRA:                    state_nx = ST_BRANCH;
                    default:                   state_nx = ST_IDLE;
                endcase
            end
            ST_PUSH:   if (last) state_nx = irq_q ? ST_VEC : ST_IDLE;
            ST_POP:    if (last) state_nx = ST_IDLE;
            ST_VEC:    if (last) state_nx = ST_IDLE;
            ST_BRANCH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= PC_RESET;
            cnt     <= '0;
            nbytes  <= CNT_W'(NB);
            far_q   <= 1'b0;
            irq_q   <= 1'b0;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            acc     <= '0;
            exc_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    cnt     <= '0;
                    tgt_q   <= target;
                    taken_q <= taken;
                    exc_q   <= exc_num;
                    irq_q   <= (op == OP_IRQ);
                    far_q   <= (op != OP_CALL);
                    nbytes  <= (op == OP_CALL) ? CNT_W'(NEAR_NB) : CNT_W'(NB);
                    if (op == OP_JMP)  pc_q[NEAR_W-1:0] <= target[NEAR_W-1:0];
                    if (op == OP_JMPF) pc_q <= target;
                end
                ST_PUSH: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) begin
                        nbytes <= CNT_W'(NB);
                        if (!irq_q) begin
                            if (far_q) pc_q <= tgt_q;
                            else       pc_q[NEAR_W-1:0] <= tgt_q[NEAR_W-1:0];
                        end
                    end
                end
                ST_POP: begin
                    cnt <= cnt + 1'b1;
                    acc <= {acc[PC_W-BYTE_W-1:0], pop_data};
                    if (last) pc_q <= {acc[PC_W-BYTE_W-1:0], pop_data};
                end
                ST_VEC: begin
                    cnt <= cnt + 1'b1;
                    acc <= {vec_data, acc[PC_W-1:BYTE_W]};
                    if (last) pc_q <= {vec_data, acc[PC_W-1:BYTE_W]};
                end
                ST_BRANCH: begin
                    if (taken_q)
                        pc_q <= pc_q + {{HI_W{tgt_q[NEAR_W-1]}}, tgt_q[NEAR_W-1:0]};
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        push_en   = (state == ST_PUSH);
        pop_en    = (state == ST_POP);
        vec_rd    = (state == ST_VEC);
        push_data = BYTE_W'(pc_q >> (int'(cnt) * BYTE_W));
        pc        = pc_q;
    end
endmodule

// File: rtl/far_pc_unit_chk.sv
module far_pc_unit_chk #(
    parameter int PC_W   = 24,
    parameter int NEAR_W = 16,
    parameter int SP_W   = 16,
    parameter logic [PC_W-1:0] VEC_BASE = 24'hFFFFF0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd,
    input logic [PC_W-1:0] target,
    input logic            busy,
    input logic [PC_W-1:0] pc,
    input logic [SP_W-1:0] sp,
    input logic            push_en,
    input logic            pop_en,
    input logic            vec_rd,
    input logic [PC_W-1:0] vec_addr
);
    a_r2_near_jump_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd == 3'd0) |=>
            (pc[PC_W-1:NEAR_W] == $past(pc[PC_W-1:NEAR_W]) &&
             pc[NEAR_W-1:0] == $past(target[NEAR_W-1:0])));

    a_r3_far_jump_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd == 3'd1) |=> (pc == $past(target)));

    a_r6_push_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (sp == $past(sp) - 1'b1));

    a_r6_pop_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> (sp == $past(sp) + 1'b1));

    a_r8_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |-> (vec_addr >= VEC_BASE));

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_en, pop_en, vec_rd}));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(push_en || pop_en || vec_rd));
endmodule

bind far_pc_unit far_pc_unit_chk #(
    .PC_W(PC_W), .NEAR_W(NEAR_W), .SP_W(SP_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .target(target), .busy(busy), .pc(pc), .sp(sp), .push_en(push_en),
    .pop_en(pop_en), .vec_rd(vec_rd), .vec_addr(vec_addr)
);

// File: tb/far_pc_unit_test.sv
`timescale 1ns/1ps
module far_pc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [23:0] target = '0;
    logic        taken = 1'b0;
    logic [1:0]  exc_num = '0;
    logic        busy, push_en, pop_en, vec_rd;
    logic [23:0] pc, vec_addr;
    logic [15:0] sp;
    logic [7:0]  push_data, pop_data, vec_data;
    logic [7:0]  stk [256];
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    far_pc_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .target(target), .taken(taken), .exc_num(exc_num), .busy(busy),
        .pc(pc), .sp(sp), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(pop_data), .vec_rd(vec_rd),
        .vec_addr(vec_addr), .vec_data(vec_data)
    );

    assign pop_data = stk[sp[7:0]];
    assign vec_data = vec_addr[7:0] ^ 8'h5A;
    always @(posedge clk) if (push_en) stk[8'(sp - 16'd1)] <= push_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [23:0] t,
                         input logic tk, input logic [1:0] e);
        cmd_valid = 1'b1; cmd = c; target = t; taken = tk; exc_num = e;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pc", pc, 32'h0);
        chk("R1 sp", sp, 32'h0100);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {push_en, pop_en, vec_rd}, 0);
    endtask

    task automatic t_jumps();
        issue(3'd1, 24'h123456, 0, 0);
        chk("R3 far jump", pc, 32'h123456);
        issue(3'd0, 24'hABCDEF, 0, 0);
        chk("R2 near jump", pc, 32'h12CDEF);
    endtask

    task automatic t_near_call();
        issue(3'd2, 24'h00BEEF, 0, 0);
        chk("R12 busy during call", busy, 1);
        wait_idle();
        chk("R4 pc", pc, 32'h12BEEF);
        chk("R4 low byte first", stk[8'hFF], 32'hEF);
        chk("R4 second byte", stk[8'hFE], 32'hCD);
        chk("R6 sp after 2 pushes", sp, 32'h00FE);
    endtask

    task automatic t_far_call_ret();
        issue(3'd3, 24'h345678, 0, 0);
        wait_idle();
        chk("R5 pc", pc, 32'h345678);
        chk("R5 stack", {stk[8'hFD], stk[8'hFC], stk[8'hFB]}, 32'hEFBE12);
        chk("R6 sp", sp, 32'h00FB);
        issue(3'd4, 0, 0, 0);
        wait_idle();
        chk("R7 pc", pc, 32'h12BEEF);
        chk("R6 sp after pops", sp, 32'h00FE);
    endtask

    task automatic t_irq_rti();
        issue(3'd5, 0, 0, 2'd2);
        wait_idle();
        chk("R8 vector pc", pc, 32'hA2ADAC);
        chk("R8 stack", {stk[8'hFD], stk[8'hFC], stk[8'hFB]}, 32'hEFBE12);
        chk("R8 sp", sp, 32'h00FB);
        issue(3'd6, 0, 0, 0);
        wait_idle();
        chk("R9 pc", pc, 32'h12BEEF);
        chk("R9 sp", sp, 32'h00FE);
    endtask

    task automatic t_branch();
        issue(3'd7, 24'h00FFF0, 1, 0);
        chk("R10 first cycle unchanged", pc, 32'h12BEEF);
        @(negedge clk);
        chk("R10 taken back", pc, 32'h12BEDF);
        issue(3'd7, 24'h000010, 0, 0);
        @(negedge clk);
        chk("R10 not taken", pc, 32'h12BEDF);
        issue(3'd1, 24'hFFFFF8, 0, 0);
        issue(3'd7, 24'h000010, 1, 0);
        @(negedge clk);
        chk("R10 wrap", pc, 32'h000008);
    endtask

    task automatic t_busy_ignore();
        issue(3'd3, 24'h0A0B0C, 0, 0);
        issue(3'd1, 24'h777777, 0, 0);
        wait_idle();
        chk("R11 command while busy ignored", pc, 32'h0A0B0C);
        chk("R11 sp", sp, 32'h00FB);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jumps();
        t_near_call();
        t_far_call_ret();
        t_irq_rti();
        t_branch();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule